// File: doc/BRIEF.md
# Serial EPROM Read Command Sequencer

This block is the byte-level command engine behind the bit-slot front end of a single-wire serial EPROM slave. The front end hands it each received byte as a one-cycle strobe. It also raises a pulse when the bus master issues a bus reset, and a one-cycle request whenever the master opens a byte-wide read window. The sequencer decodes a command byte and a two-byte start address. It then answers each read request with one byte taken from the main data array or from the paged status array, and it appends a 16-bit check word at the points the command defines.

Both arrays use synchronous reads and hold generated content. Data bytes, check bytes and filler bytes all come out on one parallel port, and the front end shifts them onto the wire with bit 0 first. The check word uses the reflected form of x^16+x^15+x^2+1 (constant 0xA001), shifts each byte in with bit 0 first, and starts from 0x0000. It is sent inverted, low byte first. A power-on reset or a bus reset always brings the engine back to waiting for a command byte.

Top module: `eprom_rd_seq`

## Requirements
- R1: After rst_n is released, tx_valid is 0, tx_byte is 0xFF and the engine waits for a command byte. A bus_rst pulse at any point drops any pending reply and clears the check generator. The next received byte is then taken as a new command. A main-array read cut short by bus_rst never produces a check word.
- R2: A transaction is a command byte, then the start address low byte, then the start address high byte. The main array uses the low 13 address bits and the status array uses the low 6 bits.
- R3: tx_req must be separated by at least one idle cycle. Each accepted tx_req gives exactly one one-cycle tx_valid pulse two clock edges later, and tx_byte holds the reply.
- R4: Command 0xF0 streams main-array bytes upward from the start address, one per request, up to address 8191. The byte at address a is ((a mod 256)*29 mod 256) XOR (a div 256) XOR 0x5A.
- R5: After main-array byte 8191, the next two replies are the inverted check word, low byte then high byte. It covers the command byte, both address bytes and every data byte sent, starting from a cleared generator.
- R6: After the main-array check word, every reply is 0xFF until a bus reset.
- R7: Command 0xAA streams status bytes up to the end of the current eight-byte page, meaning the address whose low three bits are 7. Two check bytes follow at once, and on the first page they also cover the command and address bytes. Status byte a is ((a*29) mod 256) XOR 0xC3.
- R8: On every status page after the first, the generator is cleared, so the page's check word covers only its own eight data bytes.
- R9: After the check word of status page 7 (addresses 56 to 63), every reply is 0xFF until a bus reset.
- R10: Any other command byte makes the engine ignore received bytes and reply 0xFF to every request until a bus reset.
- R11: A request made before the address is complete gets 0xFF and has no effect on the check word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| bus_rst | input | 1 | One-cycle bus reset pulse from the front end |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| tx_req | input | 1 | Read byte window request |
| tx_valid | output | 1 | Reply byte strobe |
| tx_byte | output | 8 | Reply byte, bit 0 goes to the wire first |

## Verification
Several properties are checked on every cycle. The reply arrives with a fixed latency and lasts one cycle, the request spacing rule holds, and a bus reset clears the generator and any reply. A check phase starts only at the last main address or at a page boundary, the generator stays frozen between the two check bytes, and the dead state is left only through a bus reset. The actual byte values can only be shown by the bench scenarios. These include the array contents, both check word layouts, the restart on each new status page, the filler after the final page, and the masking of high address bits. Each reply is compared against a model built from the requirements.

// File: rtl/eprom_seq_pkg.sv
package eprom_seq_pkg;

   typedef enum logic [2:0] {
      S_CMD,
      S_ADL,
      S_ADH,
      S_MAIN,
      S_STAT,
      S_CRCL,
      S_CRCH,
      S_DEAD
   } seq_state_t;

   typedef enum logic [1:0] {
      K_ONES,
      K_DATA,
      K_CRCL,
      K_CRCH
   } out_kind_t;

   localparam logic [7:0] CMD_MAIN = 8'hF0;
   localparam logic [7:0] CMD_STAT = 8'hAA;
   localparam logic [7:0] FILL     = 8'hFF;

endpackage

// File: rtl/eprom_crc16.sv
module eprom_crc16 #(
   parameter logic [15:0] POLY_R = 16'hA001,
   parameter logic [15:0] INIT   = 16'h0000,
   parameter int          DW     = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          upd,
   input  logic [DW-1:0] din,
   output logic [15:0]   crc
);

   logic [DW:0][15:0] chain;

   assign chain[0] = crc;

   // one reflected shift stage per input bit, bit 0 first
   for (genvar gi = 0; gi < DW; gi++) begin : g_bit
      assign chain[gi+1] = (chain[gi][0] ^ din[gi]) ? ((chain[gi] >> 1) ^ POLY_R)
                                                    : (chain[gi] >> 1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   crc <= INIT;
      else if (clr) crc <= INIT;
      else if (upd) crc <= chain[DW];
   end

endmodule

// File: rtl/eprom_pattern_rom.sv
module eprom_pattern_rom #(
   parameter int         AW   = 13,
   parameter logic [7:0] SEED = 8'h5A,
   parameter logic [7:0] MULT = 8'd29
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [AW-1:0] addr,
   output logic [7:0]    q
);

   logic [7:0] low8;
   logic [7:0] hi8;
   logic [7:0] prod8;

   if (AW >= 8) begin : g_low_full
      assign low8 = addr[7:0];
   end else begin : g_low_ext
      assign low8 = {{(8-AW){1'b0}}, addr};
   end

   if (AW > 8) begin : g_fold
      assign hi8 = {{(16-AW){1'b0}}, addr[AW-1:8]};
   end else begin : g_nofold
      assign hi8 = 8'h00;
   end

   assign prod8 = low8 * MULT;

   always_ff @(posedge clk) begin
      if (!rst_n)  q <= 8'h00;
      else if (en) q <= prod8 ^ hi8 ^ SEED;
   end

   initial begin
      if (AW < 1 || AW > 16) $error("pattern array width out of range");
   end

endmodule

// File: rtl/eprom_seq_ctrl.sv
module eprom_seq_ctrl
   import eprom_seq_pkg::*;
#(
   parameter int MAIN_AW = 13,
   parameter int STAT_AW = 6,
   parameter int PAGE_AW = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_rst,
   input  logic               rx_valid,
   input  logic [7:0]         rx_byte,
   input  logic               tx_req,
   output logic               main_en,
   output logic [MAIN_AW-1:0] main_a,
   output logic               stat_en,
   output logic [STAT_AW-1:0] stat_a,
   output out_kind_t          kind_q,
   output logic               src_stat_q,
   output logic               restart_q,
   output logic               pend_q,
   output logic               crc_rx_upd
);

   localparam logic [MAIN_AW-1:0] MAIN_LAST = '1;
   localparam logic [STAT_AW-1:0] STAT_LAST = '1;
   localparam logic [PAGE_AW-1:0] PAGE_END  = '1;

   seq_state_t st_q;
   logic       flow_stat_q;
   logic       last_pg_q;
   logic [7:0] adl_q;
   logic       issue;
   out_kind_t  kind_d;

   assign issue = tx_req & ~bus_rst;

   always_comb begin
      case (st_q)
         S_MAIN, S_STAT: kind_d = K_DATA;
         S_CRCL:         kind_d = K_CRCL;
         S_CRCH:         kind_d = K_CRCH;
         default:        kind_d = K_ONES;
      endcase
   end

   assign main_en    = issue && (st_q == S_MAIN);
   assign stat_en    = issue && (st_q == S_STAT);
   assign crc_rx_upd = rx_valid && !bus_rst &&
                       ((st_q == S_CMD) || (st_q == S_ADL) || (st_q == S_ADH));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q        <= S_CMD;
         flow_stat_q <= 1'b0;
         last_pg_q   <= 1'b0;
         adl_q       <= 8'h00;
         main_a      <= '0;
         stat_a      <= '0;
         kind_q      <= K_ONES;
         src_stat_q  <= 1'b0;
         restart_q   <= 1'b0;
         pend_q      <= 1'b0;
      end else if (bus_rst) begin
         st_q        <= S_CMD;
         flow_stat_q <= 1'b0;
         last_pg_q   <= 1'b0;
         restart_q   <= 1'b0;
         pend_q      <= 1'b0;
         kind_q      <= K_ONES;
      end else begin
         pend_q <= issue;
         if (issue) begin
            kind_q     <= kind_d;
            src_stat_q <= (st_q == S_STAT);
            restart_q  <= 1'b0;
         end
         case (st_q)
            S_CMD: begin
               if (rx_valid) begin
                  if (rx_byte == CMD_MAIN) begin
                     flow_stat_q <= 1'b0;
                     st_q        <= S_ADL;
                  end else if (rx_byte == CMD_STAT) begin
                     flow_stat_q <= 1'b1;
                     st_q        <= S_ADL;
                  end else begin
                     st_q <= S_DEAD;
                  end
               end
            end
            S_ADL: begin
               if (rx_valid) begin
                  adl_q <= rx_byte;
                  st_q  <= S_ADH;
               end
            end
            S_ADH: begin
               if (rx_valid) begin
                  main_a <= MAIN_AW'({rx_byte, adl_q});
                  stat_a <= STAT_AW'({rx_byte, adl_q});
                  st_q   <= flow_stat_q ? S_STAT : S_MAIN;
               end
            end
            S_MAIN: begin
               if (issue) begin
                  if (main_a == MAIN_LAST) st_q <= S_CRCL;
                  else                     main_a <= main_a + 1'b1;
               end
            end
            S_STAT: begin
               if (issue) begin
                  stat_a <= stat_a + 1'b1;
                  if (stat_a[PAGE_AW-1:0] == PAGE_END) begin
                     st_q      <= S_CRCL;
                     last_pg_q <= (stat_a == STAT_LAST);
                  end
               end
            end
            S_CRCL: begin
               if (issue) st_q <= S_CRCH;
            end
            S_CRCH: begin
               if (issue) begin
                  if (flow_stat_q && !last_pg_q) begin
                     st_q      <= S_STAT;
                     restart_q <= 1'b1;
                  end else begin
                     st_q <= S_DEAD;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   // request windows never arrive back to back
   p_req_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req |=> !tx_req);

   // main check phase starts only once the final address was served
   p_main_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_CRCL && !flow_stat_q) |-> (main_a == MAIN_LAST));

   // status check phase starts only at a page boundary
   p_page_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_CRCL && flow_stat_q) |-> (stat_a[PAGE_AW-1:0] == '0));

   // the dead state swallows everything but a bus reset
   p_dead_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_DEAD && !bus_rst) |=> (st_q == S_DEAD));

endmodule

// File: rtl/eprom_rd_seq.sv
module eprom_rd_seq
   import eprom_seq_pkg::*;
#(
   parameter int         MAIN_AW   = 13,
   parameter int         STAT_AW   = 6,
   parameter int         PAGE_AW   = 3,
   parameter logic [7:0] MAIN_SEED = 8'h5A,
   parameter logic [7:0] STAT_SEED = 8'hC3,
   parameter logic [7:0] PAT_MULT  = 8'd29
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_rst,
   input  logic       rx_valid,
   input  logic [7:0] rx_byte,
   input  logic       tx_req,
   output logic       tx_valid,
   output logic [7:0] tx_byte
);

   if (MAIN_AW < 1 || MAIN_AW > 16) begin : g_chk_main
      $error("MAIN_AW must lie in 1..16");
   end
   if (STAT_AW < PAGE_AW || STAT_AW > 16) begin : g_chk_stat
      $error("STAT_AW must lie in PAGE_AW..16");
   end
   if (PAGE_AW < 1) begin : g_chk_page
      $error("PAGE_AW must be positive");
   end

   logic               main_en, stat_en;
   logic [MAIN_AW-1:0] main_a;
   logic [STAT_AW-1:0] stat_a;
   out_kind_t          kind_q;
   logic               src_stat_q, restart_q, pend_q, crc_rx_upd;
   logic [7:0]         main_q, stat_q, data_b, byte_d, crc_din;
   logic [15:0]        crc_q;
   logic               crc_clr, crc_upd;

   eprom_seq_ctrl #(
      .MAIN_AW(MAIN_AW),
      .STAT_AW(STAT_AW),
      .PAGE_AW(PAGE_AW)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_rst   (bus_rst),
      .rx_valid  (rx_valid),
      .rx_byte   (rx_byte),
      .tx_req    (tx_req),
      .main_en   (main_en),
      .main_a    (main_a),
      .stat_en   (stat_en),
      .stat_a    (stat_a),
      .kind_q    (kind_q),
      .src_stat_q(src_stat_q),
      .restart_q (restart_q),
      .pend_q    (pend_q),
      .crc_rx_upd(crc_rx_upd)
   );

   eprom_pattern_rom #(.AW(MAIN_AW), .SEED(MAIN_SEED), .MULT(PAT_MULT)) u_main (
      .clk(clk), .rst_n(rst_n), .en(main_en), .addr(main_a), .q(main_q));

   eprom_pattern_rom #(.AW(STAT_AW), .SEED(STAT_SEED), .MULT(PAT_MULT)) u_stat (
      .clk(clk), .rst_n(rst_n), .en(stat_en), .addr(stat_a), .q(stat_q));

   assign data_b  = src_stat_q ? stat_q : main_q;
   assign crc_clr = bus_rst || (pend_q && kind_q == K_CRCH && restart_q);
   assign crc_upd = crc_rx_upd || (pend_q && kind_q == K_DATA);
   assign crc_din = crc_rx_upd ? rx_byte : data_b;

   eprom_crc16 #(.POLY_R(16'hA001), .INIT(16'h0000), .DW(8)) u_crc (
      .clk(clk), .rst_n(rst_n), .clr(crc_clr), .upd(crc_upd),
      .din(crc_din), .crc(crc_q));

   always_comb begin
      case (kind_q)
         K_DATA:  byte_d = data_b;
         K_CRCL:  byte_d = ~crc_q[7:0];
         K_CRCH:  byte_d = ~crc_q[15:8];
         default: byte_d = FILL;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_valid <= 1'b0;
         tx_byte  <= FILL;
      end else if (bus_rst) begin
         tx_valid <= 1'b0;
      end else begin
         tx_valid <= pend_q;
         if (pend_q) tx_byte <= byte_d;
      end
   end

   // every accepted request is answered two edges later
   p_reply_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_req && !bus_rst ##1 !bus_rst) |=> tx_valid);

   // a reply strobe lasts a single cycle
   p_reply_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |=> !tx_valid);

   // bus reset leaves a cleared generator and no reply
   p_bus_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_rst) |-> (crc_q == 16'h0000 && !tx_valid));

   // the generator is frozen while the high check byte is formed
   p_crc_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && kind_q == K_CRCH && !$past(bus_rst)) |-> $stable(crc_q));

endmodule

// File: tb/tb_eprom_rd_seq.sv
module tb_eprom_rd_seq;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_rst = 1'b0;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_byte = 8'h00;
   logic       tx_req = 1'b0;
   logic       tx_valid;
   logic [7:0] tx_byte;

   int checks = 0;
   int fails  = 0;

   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #4 clk = ~clk;

   eprom_rd_seq dut (
      .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .rx_valid(rx_valid),
      .rx_byte(rx_byte), .tx_req(tx_req), .tx_valid(tx_valid), .tx_byte(tx_byte));

   function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
      logic [15:0] r = c;
      for (int i = 0; i < 8; i++) begin
         if (r[0] ^ d[i]) r = (r >> 1) ^ 16'hA001;
         else             r = r >> 1;
      end
      return r;
   endfunction

   function automatic logic [7:0] main_val(input int a);
      return 8'(((a % 256) * 29) % 256) ^ 8'(a / 256) ^ 8'h5A;
   endfunction

   function automatic logic [7:0] stat_val(input int a);
      return 8'((a * 29) % 256) ^ 8'hC3;
   endfunction

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   // monitor: scoreboard pop and compare
   always @(negedge clk) begin
      if (rst_n && tx_valid) begin
         if (exp_q.size() == 0) begin
            checks++;
            fails++;
            $display("FAIL R3 unexpected reply actual=%02h expected=none", tx_byte);
         end else begin
            check(tag_q.pop_front(), tx_byte, exp_q.pop_front());
         end
      end
   end

   task automatic send(input logic [7:0] b);
      @(negedge clk);
      rx_valid = 1'b1;
      rx_byte  = b;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic bus_reset();
      @(negedge clk);
      bus_rst = 1'b1;
      @(negedge clk);
      bus_rst = 1'b0;
   endtask

   task automatic request(input logic [7:0] exp, input string tag);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      tx_req = 1'b1;
      @(negedge clk);
      tx_req = 1'b0;
      @(negedge clk);
   endtask

   task automatic drain(input string tag);
      repeat (4) @(negedge clk);
      checks++;
      if (exp_q.size() != 0) begin
         fails++;
         $display("FAIL %s missing replies actual=%0d expected=0", tag, exp_q.size());
         exp_q.delete();
         tag_q.delete();
      end
   endtask

   task automatic main_read(input logic [15:0] start, input int n);
      logic [15:0] c = 16'h0000;
      int a = start % 8192;
      int post = -1;
      c = crc_step(c, 8'hF0);
      c = crc_step(c, start[7:0]);
      c = crc_step(c, start[15:8]);
      send(8'hF0);
      send(start[7:0]);
      send(start[15:8]);
      for (int i = 0; i < n; i++) begin
         if (post < 0) begin
            c = crc_step(c, main_val(a));
            request(main_val(a), "R4");
            if (a == 8191) post = 0;
            else a++;
         end else if (post == 0) begin
            request(~c[7:0], "R5");
            post++;
         end else if (post == 1) begin
            request(~c[15:8], "R5");
            post++;
         end else begin
            request(8'hFF, "R6");
         end
      end
   endtask

   task automatic stat_read(input logic [15:0] start, input int n);
      logic [15:0] c = 16'h0000;
      int a = start % 64;
      int ph = 0;
      bit fin = 0;
      bit first = 1;
      c = crc_step(c, 8'hAA);
      c = crc_step(c, start[7:0]);
      c = crc_step(c, start[15:8]);
      send(8'hAA);
      send(start[7:0]);
      send(start[15:8]);
      for (int i = 0; i < n; i++) begin
         if (ph == 0) begin
            c = crc_step(c, stat_val(a));
            request(stat_val(a), first ? "R7" : "R8");
            if (a % 8 == 7) begin
               ph  = 1;
               fin = (a == 63);
            end
            a = (a + 1) % 64;
         end else if (ph == 1) begin
            request(~c[7:0], first ? "R7" : "R8");
            ph = 2;
         end else if (ph == 2) begin
            request(~c[15:8], first ? "R7" : "R8");
            if (fin) ph = 3;
            else begin
               ph = 0;
               c = 16'h0000;
               first = 0;
            end
         end else begin
            request(8'hFF, "R9");
         end
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : stimulus
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset valid", {7'd0, tx_valid}, 8'd0);
      check("R1 reset byte", tx_byte, 8'hFF);

      // R4 R5 R6: read through the end of the main array
      main_read(16'h1FF9, 12);
      drain("R5");
      bus_reset();

      // R1: aborted main read, then R2 high address bits ignored
      main_read(16'hE010, 5);
      drain("R1");
      bus_reset();

      // R7 R8: status read spanning the first and a later page
      stat_read(16'h0005, 15);
      drain("R8");
      bus_reset();

      // R9: last status page, high address bits masked (R2)
      stat_read(16'hAB38, 13);
      drain("R9");
      bus_reset();

      // R10: unknown command ignores later bytes
      send(8'h33);
      request(8'hFF, "R10");
      send(8'hF0);
      send(8'h00);
      send(8'h00);
      request(8'hFF, "R10");
      request(8'hFF, "R10");
      drain("R10");
      bus_reset();

      // R11: early request returns filler and leaves the check word intact
      begin
         logic [15:0] c = 16'h0000;
         c = crc_step(c, 8'hF0);
         c = crc_step(c, 8'hFE);
         c = crc_step(c, 8'h1F);
         send(8'hF0);
         request(8'hFF, "R11");
         send(8'hFE);
         request(8'hFF, "R11");
         send(8'h1F);
         c = crc_step(c, main_val(8190));
         request(main_val(8190), "R11");
         c = crc_step(c, main_val(8191));
         request(main_val(8191), "R11");
         request(~c[7:0], "R11");
         request(~c[15:8], "R11");
         drain("R11");
      end

      // R1: after bus reset a fresh transaction starts cleanly
      bus_reset();
      main_read(16'h0000, 3);
      drain("R1");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule